// File: doc/BRIEF.md
# Two-Wire Slave Front End with Write-Busy Polling

This block is the serial front end of a multi-channel register device on a two-wire bus. It oversamples the bus clock and data lines on the system clock and recognises start and stop conditions. After a start it shifts in an eight-bit slave address. The address has no direction bit. Its upper nibble is a fixed type code and its lower nibble must equal four strap pins.

A matching address is followed by a command byte. Depending on the command, the master then sends one data byte, or the slave returns one data byte. The slave acknowledges by pulling SDA low through an open-drain enable. Command and write bytes go to the register file on a one-byte output with single-cycle strobes. Read data is taken from an input byte.

A command marked nonvolatile launches an internal timed write when the stop condition ends its transaction. Until that timer expires, the slave does not acknowledge its own address. The master can therefore poll for completion by sending the address repeatedly.

Top module: `twowire_busy_slave`

## Requirements
- R1: After reset `sda_oe` is 0, and no strobe (`cmd_stb`, `wr_stb`, `nv_launch`) is pulsed while the bus stays idle.
- R2: After a start, an address byte whose bits [7:4] are 0101 and whose bits [3:0] equal `strap` is acknowledged. An acknowledge is the slave holding the SDA line low while the ninth SCL pulse is high.
- R3: An address byte that does not match is not acknowledged. Bytes that follow it are also not acknowledged and produce no strobe until the next start.
- R4: After an acknowledged address, the next byte is the command byte. It is always acknowledged, and it appears on `out_byte` with a one-cycle `cmd_stb` pulse.
- R5: When command bit 7 is 0, the first byte after the command is acknowledged and appears on `out_byte` with a one-cycle `wr_stb` pulse. Any further byte in that transaction is not acknowledged and gives no strobe.
- R6: When command bit 7 is 1, the value on `rd_byte` at the end of the command acknowledge is shifted out MSB first. The slave changes SDA only while SCL is low. The master's acknowledge bit is ignored, and the slave then releases the bus.
- R7: A stop that ends a transaction whose command had bit 7 = 0 and bit 6 = 1 pulses `nv_launch` for one cycle. For the next `NV_CYCLES` clocks, a matching address is not acknowledged. A read command with bit 6 = 1 launches nothing.
- R8: Once the nonvolatile write time has passed, a matching address is acknowledged again.
- R9: Bytes clocked without a preceding start are never acknowledged. A repeated start in the middle of a transaction returns the slave to the address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin (wired-AND value) |
| strap | input | 4 | Pin-strapped low nibble of the slave address |
| rd_byte | input | 8 | Byte returned for a read command |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| out_byte | output | 8 | Last command or write byte received |
| cmd_stb | output | 1 | One-cycle pulse: `out_byte` holds a command |
| wr_stb | output | 1 | One-cycle pulse: `out_byte` holds a write byte |
| nv_launch | output | 1 | One-cycle pulse when a nonvolatile write starts |

## Verification
The address decode is driven with random addresses against random strap values, mixed with exact matches. This separates a correct match of both nibbles from a decode that ignores either nibble. Random commands split into read and write paths: the recovered read byte shows bit order and drive timing, and the strobed bytes show capture alignment. Directed sequences cover bytes without a start, a repeated start, an extra write byte, and a read command carrying the nonvolatile bit. They also poll immediately after a nonvolatile stop and again after the timer. Together these tell the busy refusal apart from a plain address mismatch.

// File: rtl/twowire_busy_slave.sv
module twowire_busy_slave #(
  parameter logic [3:0] TYPE_ID   = 4'b0101,
  parameter int         NV_CYCLES = 625000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [3:0] strap,
  input  logic [7:0] rd_byte,
  output logic       sda_oe,
  output logic [7:0] out_byte,
  output logic       cmd_stb,
  output logic       wr_stb,
  output logic       nv_launch
);
  localparam int BW = $clog2(NV_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_DATA, S_RD} st_t;

  logic [2:0] scl_sy, sda_sy;
  logic       scl_s, scl_q, sda_s, sda_q;
  logic       scl_rise, scl_fall, start_det, stop_det;
  st_t        state;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       is_rd, nv_pend;
  logic [BW-1:0] busy_cnt;
  logic       busy, addr_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_in};
      sda_sy <= {sda_sy[1:0], sda_in};
    end

  assign scl_s     = scl_sy[1];
  assign scl_q     = scl_sy[2];
  assign sda_s     = sda_sy[1];
  assign sda_q     = sda_sy[2];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign busy      = busy_cnt != '0;
  assign addr_hit  = (sh == {TYPE_ID, strap}) && !busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      sh        <= '0;
      sda_oe    <= 1'b0;
      is_rd     <= 1'b0;
      nv_pend   <= 1'b0;
      busy_cnt  <= '0;
      out_byte  <= '0;
      cmd_stb   <= 1'b0;
      wr_stb    <= 1'b0;
      nv_launch <= 1'b0;
    end else begin
      cmd_stb   <= 1'b0;
      wr_stb    <= 1'b0;
      nv_launch <= 1'b0;
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (start_det) begin
        state   <= S_ADDR;
        cnt     <= '0;
        sda_oe  <= 1'b0;
        nv_pend <= 1'b0;
      end else if (stop_det) begin
        state  <= S_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
        if (nv_pend) begin
          nv_pend   <= 1'b0;
          nv_launch <= 1'b1;
          busy_cnt  <= BW'(NV_CYCLES);
        end
      end else if (state != S_IDLE) begin
        if (scl_rise && cnt < 4'd9) begin
          cnt <= cnt + 1'b1;
          if (state != S_RD && cnt < 4'd8) sh <= {sh[6:0], sda_s};
        end
        if (scl_fall) begin
          if (cnt == 4'd8) begin
            case (state)
              S_ADDR: if (addr_hit) sda_oe <= 1'b1;
                      else begin
                        state <= S_IDLE;
                        cnt   <= '0;
                      end
              S_CMD: begin
                sda_oe   <= 1'b1;
                out_byte <= sh;
                cmd_stb  <= 1'b1;
                is_rd    <= sh[7];
                nv_pend  <= !sh[7] && sh[6];
              end
              S_DATA: begin
                sda_oe   <= 1'b1;
                out_byte <= sh;
                wr_stb   <= 1'b1;
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (cnt == 4'd9) begin
            cnt <= '0;
            case (state)
              S_ADDR: begin
                state  <= S_CMD;
                sda_oe <= 1'b0;
              end
              S_CMD: if (is_rd) begin
                       state  <= S_RD;
                       sh     <= rd_byte;
                       sda_oe <= ~rd_byte[7];
                     end else begin
                       state  <= S_DATA;
                       sda_oe <= 1'b0;
                     end
              default: begin
                state  <= S_IDLE;
                sda_oe <= 1'b0;
              end
            endcase
          end else if (state == S_RD && cnt != 4'd0) begin
            sh     <= {sh[6:0], 1'b0};
            sda_oe <= ~sh[6];
          end
        end
      end
    end

  a_r6_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);
  a_r3_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_oe);
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_stb && wr_stb));
  a_r7_launch_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    nv_launch |-> $past(stop_det));
  a_r7_busy_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
    nv_launch |-> busy);
  a_r7_no_cmd_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_stb);
endmodule

// File: tb/twowire_busy_slave_bench.sv
module twowire_busy_slave_bench;
  localparam int NV = 400;
  localparam int Q  = 6;

  logic clk = 0, rst_n = 0, scl = 1, sda_m = 1;
  logic [3:0] strap = 4'h3;
  logic [7:0] rd_byte = 8'h00;
  logic sda_oe, cmd_stb, wr_stb, nv_launch;
  logic [7:0] out_byte;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, failures = 0;
  int n_cmd = 0, n_wr = 0, n_nv = 0;
  logic [7:0] last_cmd = 0, last_wr = 0;
  bit done = 0;

  twowire_busy_slave #(.NV_CYCLES(NV)) u_twowire_busy_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .strap(strap),
    .rd_byte(rd_byte), .sda_oe(sda_oe), .out_byte(out_byte), .cmd_stb(cmd_stb),
    .wr_stb(wr_stb), .nv_launch(nv_launch));

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (cmd_stb) begin n_cmd++; last_cmd = out_byte; end
    if (wr_stb) begin n_wr++; last_wr = out_byte; end
    if (nv_launch) n_nv++;
  end

  function automatic bit exp_ack(input [7:0] a, input [3:0] s, input bit bsy);
    return (a == {4'b0101, s}) && !bsy;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic w; repeat (Q) @(negedge clk); endtask

  task automatic start_c;
    sda_m = 1; w; scl = 1; w; sda_m = 0; w; scl = 0; w;
  endtask

  task automatic stop_c;
    sda_m = 0; w; scl = 1; w; sda_m = 1; w;
  endtask

  task automatic send_byte(input [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w; scl = 1; w; w; scl = 0; w;
    end
    sda_m = 1; w; scl = 1; w; acked = (sda_line == 1'b0); w; scl = 0; w;
  endtask

  task automatic recv_byte(input bit mack, output [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      w; scl = 1; w; b[i] = sda_line; w; scl = 0;
    end
    w; sda_m = mack ? 1'b0 : 1'b1; w; scl = 1; w; w; scl = 0; w; sda_m = 1;
  endtask

  initial begin : watchdog
    repeat (190000) @(negedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    bit a, b;
    logic [7:0] rb, addr, cmd, dat;
    int c0, w0, v0;
    void'($urandom(32'd2718));
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (20) @(negedge clk);
    chk(sda_oe == 0 && n_cmd == 0 && n_wr == 0 && n_nv == 0, "R1 reset idle", sda_oe, 0);

    send_byte({4'b0101, strap}, a);
    chk(!a, "R9 no start no ack", a, 0);
    stop_c;

    start_c; send_byte(8'h53, a);
    chk(a, "R2 address ack", a, 1);
    start_c; send_byte(8'h53, a);
    chk(a, "R9 repeated start address ack", a, 1);
    c0 = n_cmd; send_byte(8'h05, b);
    chk(b && n_cmd == c0 + 1 && last_cmd == 8'h05, "R4 command strobe", last_cmd, 8'h05);
    w0 = n_wr; send_byte(8'h3C, b);
    chk(b && n_wr == w0 + 1 && last_wr == 8'h3C, "R5 data strobe", last_wr, 8'h3C);
    send_byte(8'h77, b);
    chk(!b && n_wr == w0 + 1, "R5 extra byte refused", n_wr - w0, 1);
    stop_c;

    start_c; send_byte(8'h5C, a);
    c0 = n_cmd; send_byte(8'h05, b);
    chk(!a && !b && n_cmd == c0, "R3 mismatch ignored", {a, b}, 0);
    stop_c;

    rd_byte = 8'hA6;
    start_c; send_byte(8'h53, a); send_byte(8'hC0, b); recv_byte(1'b1, rb); stop_c;
    chk(rb == 8'hA6, "R6 read byte", rb, 8'hA6);
    chk(n_nv == 0, "R7 read with bit6 launches nothing", n_nv, 0);

    for (int k = 0; k < 40; k++) begin
      strap = 4'($urandom);
      addr = ($urandom % 2) ? {4'b0101, strap} : 8'($urandom);
      cmd = 8'($urandom) & 8'hBF;
      dat = 8'($urandom);
      rd_byte = 8'($urandom);
      c0 = n_cmd; w0 = n_wr;
      start_c; send_byte(addr, a);
      chk(a == exp_ack(addr, strap, 0), "R2 random address", a, exp_ack(addr, strap, 0));
      send_byte(cmd, b);
      if (a) begin
        chk(b && n_cmd == c0 + 1 && last_cmd == cmd, "R4 random command", last_cmd, cmd);
        if (cmd[7]) begin
          recv_byte(k[0], rb);
          chk(rb == rd_byte, "R6 random read", rb, rd_byte);
        end else begin
          send_byte(dat, b);
          chk(b && n_wr == w0 + 1 && last_wr == dat, "R5 random write", last_wr, dat);
        end
      end else begin
        chk(!b && n_cmd == c0, "R3 random mismatch", b, 0);
      end
      stop_c;
    end

    strap = 4'h9;
    v0 = n_nv;
    start_c; send_byte(8'h59, a); send_byte(8'h41, b); send_byte(8'h99, b); stop_c;
    chk(n_nv == v0 + 1, "R7 launch at stop", n_nv - v0, 1);
    start_c; send_byte(8'h59, a); stop_c;
    chk(a == exp_ack(8'h59, strap, 1), "R7 busy refusal", a, 0);
    repeat (NV + 50) @(negedge clk);
    start_c; send_byte(8'h59, a); stop_c;
    chk(a == exp_ack(8'h59, strap, 0), "R8 ack after write", a, 1);
    chk(n_nv == v0 + 1, "R7 no relaunch on poll", n_nv - v0, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule